// File: doc/BRIEF.md
# Core Power-State Sequencer

This block follows a processor core through its clock-stopped and halted conditions and decides when it runs again. It tracks six states: running, halted, halted at a reduced operating point, clock-stopped, and two snoop-service states. A request to stop clocks or to halt moves the core out of the running state. While the core sits in one of these quiet states, a bus snoop or a bus interrupt moves it into a snoop-service state. Once that work is finished, the core goes back to the quiet state it came from.

While clocks are stopped, the block collects side-band events and bus interrupts instead of servicing them. There are five event pins: a management interrupt, a soft init, a bus-error init, and two local interrupt lines. Repeated arrivals from one source collapse into a single pending flag. A break-pending output tells the system that the core has work waiting. On the return to running, every collected source is handed on as a one-cycle pulse. The block has no interrupt-mask input, so an interrupt that the core would mask still raises break-pending.

Top module: `lp_state_ctrl`

## Requirements
- R1: While and after the block reset, `state_o` is 6'b000001 (running) and `evt_rel_o`, `irq_rel_o`, `brk_pend_o` and `low_op_o` are all 0.
- R2: `state_o` is one-hot with bit 0 = running, bit 1 = halt, bit 2 = reduced-point halt, bit 3 = clock-stopped, bit 4 = snoop service, bit 5 = reduced-point snoop. From running, `stop_req_i` leads to clock-stopped on the next cycle and takes priority over `halt_req_i`. `halt_req_i` alone leads to reduced-point halt when `ehalt_en_i` is 1, and to plain halt otherwise.
- R3: From clock-stopped, the cycle after `stop_req_i` is low the state is running. From either halt state, the cycle after `halt_req_i` is low (with no snoop and no interrupt) the state is running.
- R4: `core_rst_i` in clock-stopped with `stop_req_i` held keeps the state clock-stopped and clears all pending flags, so nothing is released later. `core_rst_i` in running or in either halt state forces running.
- R5: `snoop_hit_i` or `irq_dlv_i` leads to snoop service (bit 4) on the next cycle when it arrives in clock-stopped or halt, and to reduced-point snoop (bit 5) when it arrives in reduced-point halt.
- R6: A snoop-service state returns to the state it was entered from on the cycle after `snoop_done_i`. It stays put until then. If the entry was caused by `irq_dlv_i` without `snoop_hit_i`, it returns on the cycle after entry.
- R7: Event pins and `irq_dlv_i` are latched only in clock-stopped or in a snoop service entered from it. In running or in either halt state they have no effect, and nothing is released for them.
- R8: On the transition from clock-stopped to running, `evt_rel_o` (bit 0 management interrupt, bit 1 init, bit 2 bus-error init, bit 3 local line 0, bit 4 local line 1) and `irq_rel_o` pulse for exactly one cycle, aligned with the first running cycle, for each pending source. Repeated arrivals give one pulse. All flags are cleared.
- R9: `brk_pend_o` is 1 exactly when the state is clock-stopped and at least one flag is pending. No mask condition applies.
- R10: `low_op_o` is 1 exactly in reduced-point halt and reduced-point snoop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| stop_req_i | input | 1 | Clock-stop request, level |
| halt_req_i | input | 1 | Halt request, level |
| ehalt_en_i | input | 1 | Select the reduced-operating-point halt |
| core_rst_i | input | 1 | Core reset request |
| snoop_hit_i | input | 1 | Bus snoop detected |
| snoop_done_i | input | 1 | Snoop serviced by any agent |
| irq_dlv_i | input | 1 | Interrupt delivered over the bus |
| evt_i | input | N_PINS | Side-band event pins |
| state_o | output | 6 | One-hot current state |
| evt_rel_o | output | N_PINS | Released event pulses |
| irq_rel_o | output | 1 | Released bus-interrupt pulse |
| brk_pend_o | output | 1 | Pending work while clock-stopped |
| low_op_o | output | 1 | Reduced operating point active |

## Verification
The bench drives the same events in three contexts: running, halted and clock-stopped. Only the clock-stopped pass may later show release pulses, which separates latching from ignoring. Snoop service is entered by snoop strobes and by interrupt strobes from each quiet state. Comparing the return state tells apart an interrupt-only entry, a snoop that waits for completion, and the correct return target. Repeated and mixed event patterns, followed by a core reset while clocks are stopped, distinguish collapsing, release and clearing of the pending flags.

// File: rtl/lp_pkg.sv
package lp_pkg;

    typedef enum logic [5:0] {
        ST_RUN   = 6'b000001,
        ST_HALT  = 6'b000010,
        ST_EHALT = 6'b000100,
        ST_STOP  = 6'b001000,
        ST_SNP   = 6'b010000,
        ST_ESNP  = 6'b100000
    } lp_state_e;

    typedef struct packed {
        lp_state_e cur;
        lp_state_e ret;
        logic      by_irq;
    } lp_fsm_t;

endpackage

// File: rtl/lp_fsm.sv
module lp_fsm
    import lp_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      stop_req_i,
    input  logic      halt_req_i,
    input  logic      ehalt_en_i,
    input  logic      core_rst_i,
    input  logic      snoop_hit_i,
    input  logic      snoop_done_i,
    input  logic      irq_dlv_i,
    output lp_state_e state_o,
    output logic      stopped_o,
    output logic      release_o
);

    lp_fsm_t fsm_d, fsm_q;
    logic    wake_evt;

    assign wake_evt = snoop_hit_i | irq_dlv_i;

    always_comb begin
        fsm_d     = fsm_q;
        stopped_o = (fsm_q.cur == ST_STOP) ||
                    ((fsm_q.cur == ST_SNP) && (fsm_q.ret == ST_STOP));
        release_o = (fsm_q.cur == ST_STOP) && !stop_req_i && !core_rst_i;
        case (fsm_q.cur)
            ST_RUN: begin
                if (core_rst_i)       fsm_d.cur = ST_RUN;
                else if (stop_req_i)  fsm_d.cur = ST_STOP;
                else if (halt_req_i)  fsm_d.cur = ehalt_en_i ? ST_EHALT : ST_HALT;
            end
            ST_STOP: begin
                if (!stop_req_i) begin
                    fsm_d.cur = ST_RUN;
                end else if (!core_rst_i && wake_evt) begin
                    fsm_d.cur    = ST_SNP;
                    fsm_d.ret    = ST_STOP;
                    fsm_d.by_irq = irq_dlv_i & ~snoop_hit_i;
                end
            end
            ST_HALT, ST_EHALT: begin
                if (core_rst_i) begin
                    fsm_d.cur = ST_RUN;
                end else if (wake_evt) begin
                    fsm_d.cur    = (fsm_q.cur == ST_EHALT) ? ST_ESNP : ST_SNP;
                    fsm_d.ret    = fsm_q.cur;
                    fsm_d.by_irq = irq_dlv_i & ~snoop_hit_i;
                end else if (!halt_req_i) begin
                    fsm_d.cur = ST_RUN;
                end
            end
            ST_SNP, ST_ESNP: begin
                if (core_rst_i && (fsm_q.ret != ST_STOP)) begin
                    fsm_d.cur = ST_RUN;
                end else if (snoop_done_i || fsm_q.by_irq) begin
                    fsm_d.cur    = fsm_q.ret;
                    fsm_d.by_irq = 1'b0;
                end
            end
            default: fsm_d.cur = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q <= '{cur: ST_RUN, ret: ST_RUN, by_irq: 1'b0};
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign state_o = fsm_q.cur;

    // R2
    state_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(fsm_q.cur) == 1);

    // R3
    stop_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.cur == ST_STOP && !stop_req_i) |=> (fsm_q.cur == ST_RUN));

    // R4
    stop_rst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.cur == ST_STOP && stop_req_i && core_rst_i) |=> (fsm_q.cur == ST_STOP));

    // R5
    ehalt_snoop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.cur == ST_EHALT && snoop_hit_i && !core_rst_i) |=> (fsm_q.cur == ST_ESNP));

    // R6
    esnoop_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.cur == ST_ESNP && snoop_done_i && !core_rst_i) |=> (fsm_q.cur == ST_EHALT));

endmodule

// File: rtl/lp_pend_bank.sv
module lp_pend_bank #(
    parameter int WIDTH = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             clr_i,
    input  logic             rel_i,
    input  logic [WIDTH-1:0] src_i,
    output logic [WIDTH-1:0] pend_o,
    output logic [WIDTH-1:0] pulse_o
);

    typedef struct packed {
        logic [WIDTH-1:0] pend;
        logic [WIDTH-1:0] pulse;
    } bank_t;

    bank_t            bank_d, bank_q;
    logic [WIDTH-1:0] pend_nx, pulse_nx;

    for (genvar i = 0; i < WIDTH; i++) begin : g_src
        logic merged;
        assign merged      = bank_q.pend[i] | (en_i & src_i[i]);
        assign pend_nx[i]  = !clr_i && !rel_i && merged;
        assign pulse_nx[i] = !clr_i && rel_i && merged;
    end

    always_comb begin
        bank_d.pend  = pend_nx;
        bank_d.pulse = pulse_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign pend_o  = bank_q.pend;
    assign pulse_o = bank_q.pulse;

    // R8
    rel_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rel_i |=> (bank_q.pend == '0));

    // R4
    clr_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (bank_q.pend == '0 && bank_q.pulse == '0));

    // R8
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_q.pulse != '0) |=> (bank_q.pulse == '0));

endmodule

// File: rtl/lp_state_ctrl.sv
module lp_state_ctrl
    import lp_pkg::*;
#(
    parameter int N_PINS = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stop_req_i,
    input  logic              halt_req_i,
    input  logic              ehalt_en_i,
    input  logic              core_rst_i,
    input  logic              snoop_hit_i,
    input  logic              snoop_done_i,
    input  logic              irq_dlv_i,
    input  logic [N_PINS-1:0] evt_i,
    output logic [5:0]        state_o,
    output logic [N_PINS-1:0] evt_rel_o,
    output logic              irq_rel_o,
    output logic              brk_pend_o,
    output logic              low_op_o
);

    localparam int SRC_W = N_PINS + 1;

    lp_state_e        cur_st;
    logic             stopped, release_now;
    logic [SRC_W-1:0] pend, pulse;

    lp_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .stop_req_i   (stop_req_i),
        .halt_req_i   (halt_req_i),
        .ehalt_en_i   (ehalt_en_i),
        .core_rst_i   (core_rst_i),
        .snoop_hit_i  (snoop_hit_i),
        .snoop_done_i (snoop_done_i),
        .irq_dlv_i    (irq_dlv_i),
        .state_o      (cur_st),
        .stopped_o    (stopped),
        .release_o    (release_now)
    );

    lp_pend_bank #(.WIDTH(SRC_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (stopped),
        .clr_i   (core_rst_i),
        .rel_i   (release_now),
        .src_i   ({irq_dlv_i, evt_i}),
        .pend_o  (pend),
        .pulse_o (pulse)
    );

    assign state_o    = cur_st;
    assign evt_rel_o  = pulse[N_PINS-1:0];
    assign irq_rel_o  = pulse[N_PINS];
    assign brk_pend_o = (cur_st == ST_STOP) && (|pend);
    assign low_op_o   = (cur_st == ST_EHALT) || (cur_st == ST_ESNP);

    // R8
    rel_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|pulse) |-> state_o[0]);

    // R10
    lowop_snoop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (low_op_o && snoop_hit_i && !core_rst_i && state_o[2]) |=> low_op_o);

    // R7
    run_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o[0] && !stop_req_i) |=> (pend == $past(pend)));

endmodule

// File: tb/lp_state_ctrl_bench.sv
module lp_state_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       stop_req, halt_req, ehalt_en, core_rst, snp_hit, snp_done, irq_dlv;
    logic [4:0] evt;
    logic [5:0] state;
    logic [4:0] evt_rel;
    logic       irq_rel, brk_pend, low_op;

    int tests_run = 0;
    int tests_failed = 0;
    int wd_cycles = 0;

    typedef struct {
        logic [5:0] st;
        logic [4:0] rel;
        logic       irel;
        logic       brk;
        logic       low;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    exp_t cur_e;

    always #5 clk = ~clk;

    lp_state_ctrl #(.N_PINS(5)) u_lp_state_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .stop_req_i   (stop_req),
        .halt_req_i   (halt_req),
        .ehalt_en_i   (ehalt_en),
        .core_rst_i   (core_rst),
        .snoop_hit_i  (snp_hit),
        .snoop_done_i (snp_done),
        .irq_dlv_i    (irq_dlv),
        .evt_i        (evt),
        .state_o      (state),
        .evt_rel_o    (evt_rel),
        .irq_rel_o    (irq_rel),
        .brk_pend_o   (brk_pend),
        .low_op_o     (low_op)
    );

    task automatic compare(input exp_t e);
        tests_run++;
        if (state !== e.st || evt_rel !== e.rel || irq_rel !== e.irel ||
            brk_pend !== e.brk || low_op !== e.low) begin
            tests_failed++;
            $display("FAIL %s: got st=%b rel=%b irel=%b brk=%b low=%b, expected st=%b rel=%b irel=%b brk=%b low=%b",
                     e.tag, state, evt_rel, irq_rel, brk_pend, low_op,
                     e.st, e.rel, e.irel, e.brk, e.low);
        end
    endtask

    // monitor: compares after each active edge
    always @(posedge clk) begin
        #1;
        if (rst_n && exp_q.size() > 0) begin
            cur_e = exp_q.pop_front();
            compare(cur_e);
        end
    end

    task automatic drive(input logic s, input logic h, input logic eh,
                         input logic sh, input logic sd, input logic ir,
                         input logic [4:0] ev, input logic cr,
                         input logic [5:0] est, input logic [4:0] erel,
                         input logic eirel, input logic ebrk, input logic elow,
                         input string tag);
        exp_t e;
        @(negedge clk);
        stop_req = s; halt_req = h; ehalt_en = eh; snp_hit = sh;
        snp_done = sd; irq_dlv = ir; evt = ev; core_rst = cr;
        e.st = est; e.rel = erel; e.irel = eirel; e.brk = ebrk; e.low = elow; e.tag = tag;
        exp_q.push_back(e);
    endtask

    initial begin
        while (wd_cycles < 5000) begin
            @(posedge clk);
            wd_cycles++;
        end
        tests_failed++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

    initial begin
        exp_t r;
        stop_req = 0; halt_req = 0; ehalt_en = 0; snp_hit = 0;
        snp_done = 0; irq_dlv = 0; evt = '0; core_rst = 0;
        repeat (3) @(negedge clk);
        r.st = 6'b000001; r.rel = '0; r.irel = 0; r.brk = 0; r.low = 0; r.tag = "R1 in reset";
        compare(r);
        rst_n = 1'b1;
        //     s h e sh sd ir ev       cr st         rel      ir b l
        drive(0,0,0,0,0,0,5'b00000,0,6'b000001,5'b00000,0,0,0,"R1 after reset");
        drive(1,0,0,0,0,0,5'b00000,0,6'b001000,5'b00000,0,0,0,"R2 run to stop");
        drive(1,0,0,0,0,0,5'b00001,0,6'b001000,5'b00000,0,1,0,"R9 smi latched");
        drive(1,0,0,0,0,0,5'b10001,0,6'b001000,5'b00000,0,1,0,"R8 repeat smi plus lint1");
        drive(1,0,0,0,0,1,5'b00000,0,6'b010000,5'b00000,0,0,0,"R5 irq from stop");
        drive(1,0,0,0,0,0,5'b00000,0,6'b001000,5'b00000,0,1,0,"R6 irq-only return");
        drive(1,0,0,1,0,0,5'b00000,0,6'b010000,5'b00000,0,0,0,"R5 snoop from stop");
        drive(1,0,0,0,0,0,5'b00010,0,6'b010000,5'b00000,0,0,0,"R7 init during stop snoop");
        drive(1,0,0,0,1,0,5'b00000,0,6'b001000,5'b00000,0,1,0,"R6 snoop done to stop");
        drive(0,0,0,0,0,0,5'b00000,0,6'b000001,5'b10011,1,0,0,"R8 release on wake");
        drive(0,0,0,0,0,0,5'b00000,0,6'b000001,5'b00000,0,0,0,"R8 one-cycle pulse");
        drive(0,0,0,0,0,1,5'b11111,0,6'b000001,5'b00000,0,0,0,"R7 events in run");
        drive(1,0,0,0,0,0,5'b00000,0,6'b001000,5'b00000,0,0,0,"R7 nothing kept from run");
        drive(1,0,0,0,0,0,5'b00100,0,6'b001000,5'b00000,0,1,0,"R9 binit latched");
        drive(1,0,0,0,0,0,5'b00000,1,6'b001000,5'b00000,0,0,0,"R4 core reset holds stop");
        drive(0,0,0,0,0,0,5'b00000,0,6'b000001,5'b00000,0,0,0,"R4 nothing released");
        drive(0,1,0,0,0,0,5'b00000,0,6'b000010,5'b00000,0,0,0,"R2 plain halt");
        drive(0,1,0,1,0,0,5'b00000,0,6'b010000,5'b00000,0,0,0,"R5 snoop from halt");
        drive(0,1,0,0,0,0,5'b00000,0,6'b010000,5'b00000,0,0,0,"R6 waits for done");
        drive(0,1,0,0,1,0,5'b00000,0,6'b000010,5'b00000,0,0,0,"R6 back to halt");
        drive(0,0,0,0,0,0,5'b00000,0,6'b000001,5'b00000,0,0,0,"R3 halt exit");
        drive(0,1,1,0,0,0,5'b00000,0,6'b000100,5'b00000,0,0,1,"R10 reduced halt");
        drive(0,1,1,1,0,0,5'b00000,0,6'b100000,5'b00000,0,0,1,"R5 reduced snoop");
        drive(0,1,1,0,1,0,5'b00000,0,6'b000100,5'b00000,0,0,1,"R6 back to reduced halt");
        drive(0,1,1,0,0,1,5'b01000,0,6'b100000,5'b00000,0,0,1,"R5 irq from reduced halt");
        drive(0,1,1,0,0,0,5'b00000,0,6'b000100,5'b00000,0,0,1,"R6 irq-only reduced return");
        drive(0,0,0,0,0,0,5'b00000,0,6'b000001,5'b00000,0,0,0,"R7 halt events not kept");
        drive(1,1,0,0,0,0,5'b00000,0,6'b001000,5'b00000,0,0,0,"R2 stop beats halt");
        drive(1,0,0,0,0,0,5'b01000,0,6'b001000,5'b00000,0,1,0,"R9 lint0 latched");
        drive(0,0,0,0,0,0,5'b00000,0,6'b000001,5'b01000,0,0,0,"R8 lint0 released");
        drive(0,1,0,0,0,0,5'b00000,1,6'b000001,5'b00000,0,0,0,"R4 core reset in run");
        drive(0,0,0,0,0,0,5'b00000,0,6'b000001,5'b00000,0,0,0,"R3 idle run");
        repeat (3) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

endmodule